// File: doc/BRIEF.md
# Latched-Address Byte Memory with Precharge Enforcement

This block is a clock-sampled model of an 8K x 8 byte-wide memory whose access cycle is framed by an active-low chip enable. Chip enable, write enable and output enable are all active low and are sampled on the system clock. The address is taken once, on the clock where chip enable is first seen low. After that the address pins have no effect until the next access. A cycle is a read or a write depending on write enable, and a read cycle becomes a write if write enable falls while chip enable is still low.

Between accesses, chip enable must stay high for a minimum number of clocks (the precharge interval). A falling chip enable that arrives too early is ignored and raises a sticky violation flag. A supply-good input gates all activity. While it is low, every access is ignored, and when it returns, chip enable must again satisfy a full precharge interval before any access is accepted.

Read data reaches the output register a fixed number of clocks after the capture clock, whatever output enable does. The bidirectional bus is split into data-in, data-out and a drive-enable.

Top module: `latched_nvram`

## Requirements
- R1: The array holds 2^ADDR_W bytes (default 8,192, 13-bit address). A byte written at an address is returned by a later read of that address.
- R2: The address is captured on the clock where ce_n is first sampled low. Changes on addr for the rest of that access have no effect on which location is read or written.
- R3: If we_n is high at capture, the access is a read. If we_n is low at capture, the access is a write. A read becomes a write if we_n is sampled falling while ce_n is low.
- R4: For a write, din is stored on the first clock where we_n or ce_n is sampled high after the access became a write. Exactly one byte is stored per access, and a second write-enable pulse in the same access stores nothing.
- R5: For a read, dout is loaded from the array ACCESS_LAT clocks after the capture clock (default 18) and keeps its previous value until then. This happens for either level of oe_n.
- R6: dout_en is 1 only while ce_n and oe_n are both low during an accepted read access, starting the clock after capture. It is 0 during writes and when no access is active.
- R7: A write completes with oe_n low just as it does with oe_n high.
- R8: An access is accepted only if ce_n was sampled high, with supply_ok high, on at least PRECHARGE_CYC consecutive clocks (default 13) immediately before the capture clock. Otherwise the whole access is ignored and memory is unchanged.
- R9: While supply_ok is 0, no access is accepted, nothing is written and the violation flag is not set. After supply_ok returns, a full precharge interval counted from its return is needed.
- R10: early_ce_flag becomes 1 when ce_n falls with supply_ok high before the precharge interval has completed. It stays 1 until reset.
- R11: Synchronous active-low reset clears dout to 0, dout_en to 0 and early_ce_flag to 0, and restarts the precharge interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | High when the supply is good; low blocks all accesses |
| ce_n | input | 1 | Active-low chip enable, frames each access |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address, captured when ce_n falls |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data register |
| dout_en | output | 1 | Bus drive enable for dout |
| early_ce_flag | output | 1 | Sticky flag for a chip-enable fall before precharge completed |

## Verification
The checker watches, on every clock, the rules that never depend on data. The bus is never driven without both enables low. The captured address stays frozen while an access is active. No access starts without a full precharge run, as counted by a counter kept inside the checker. No array write happens while the supply is bad. No two array writes fall on consecutive clocks. The violation flag never clears.

Only the bench's scenarios can show the behaviours that need data or timing. These are: the correct bytes at every address after each of the three write styles, the exact clock where read data appears, and that output enable leaves reads and writes untouched. They also include a precharge interval of exactly the minimum length being accepted, and one clock short being rejected.

// File: rtl/nvram_pkg.sv
// Package: shared types for the latched-address memory model.
// Assumes nothing beyond plain SystemVerilog.
package nvram_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } nv_state_t;
endpackage

// File: rtl/nvram_precharge.sv
// Precharge timer: counts clocks on which chip enable is high with a good
// supply, saturating at PRECHARGE_CYC. ready is high once a full interval
// has elapsed. Assumes PRECHARGE_CYC >= 1 and synchronous inputs.
module nvram_precharge #(
    parameter int PRECHARGE_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ce_n,
    output logic ready
);
    localparam int CW = $clog2(PRECHARGE_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(PRECHARGE_CYC);

    logic [CW-1:0] cnt;

    // Count high chip-enable clocks; any low clock or bad supply restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!supply_ok || !ce_n) begin
            cnt <= '0;
        end else if (cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == FULL);
endmodule

// File: rtl/nvram_array.sv
// Storage array: one synchronous write port and one combinational read
// port. No reset: contents are undefined until written, as for any RAM.
module nvram_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte when the controller commits a write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvram_ctrl.sv
// Access controller: detects chip-enable and write-enable edges by sampling,
// accepts an access only when precharge is ready and supply is good,
// latches the address once, times the read latency and commits at most one
// write per access. Assumes inputs are synchronous to clk, ACCESS_LAT >= 1.
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int ACCESS_LAT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              write_mode,
    output logic              early_flag
);
    localparam int LW = $clog2(ACCESS_LAT + 1);
    localparam logic [LW-1:0] LAT_LAST = LW'(ACCESS_LAT - 1);
    localparam logic [LW-1:0] LAT_MAX  = LW'(ACCESS_LAT);

    nv_state_t   state;
    logic        ce_q;
    logic        we_q;
    logic        wr_q;
    logic        done_q;
    logic [LW-1:0] lat;
    logic        ce_fall;
    logic        we_fall;
    logic        we_rise;
    logic        commit;

    // Edge detection from the previous sample of each strobe.
    always_comb begin
        ce_fall = ce_q & ~ce_n;
        we_fall = we_q & ~we_n;
        we_rise = ~we_q & we_n;
    end

    // A write commits on the first high strobe of a write access.
    always_comb begin
        commit = (state == ST_BUSY) && supply_ok && wr_q && !done_q
                 && (we_rise || ce_n);
    end

    // Access sequencing, address capture, read timing and violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ce_q       <= 1'b1;
            we_q       <= 1'b1;
            wr_q       <= 1'b0;
            done_q     <= 1'b0;
            lat        <= '0;
            lat_addr   <= '0;
            rdata      <= '0;
            early_flag <= 1'b0;
        end else begin
            ce_q <= ce_n;
            we_q <= we_n;
            case (state)
                ST_IDLE: begin
                    if (ce_fall && supply_ok) begin
                        if (ready) begin
                            state    <= ST_BUSY;
                            lat_addr <= addr;
                            wr_q     <= ~we_n;
                            done_q   <= 1'b0;
                            lat      <= '0;
                        end else begin
                            early_flag <= 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (!supply_ok) begin
                        state <= ST_IDLE;
                    end else begin
                        if (lat != LAT_MAX) begin
                            lat <= lat + 1'b1;
                        end
                        if (!wr_q && lat == LAT_LAST) begin
                            rdata <= mem_rdata;
                        end
                        if (!wr_q && we_fall) begin
                            wr_q <= 1'b1;
                        end
                        if (commit) begin
                            done_q <= 1'b1;
                        end
                        if (ce_n) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_we     = commit;
    assign mem_wdata  = din;
    assign busy       = (state == ST_BUSY);
    assign write_mode = wr_q;
endmodule

// File: rtl/latched_nvram.sv
// Top: latched-address byte memory model. Connects the precharge timer,
// the access controller and the storage array, and forms the bus drive
// enable. Assumes all strobes are synchronous to clk.
module latched_nvram #(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int PRECHARGE_CYC = 13,
    parameter int ACCESS_LAT    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              early_ce_flag
);
    logic              ready;
    logic [ADDR_W-1:0] lat_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              busy;
    logic              write_mode;

    nvram_precharge #(
        .PRECHARGE_CYC(PRECHARGE_CYC)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ce_n      (ce_n),
        .ready     (ready)
    );

    nvram_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ACCESS_LAT (ACCESS_LAT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .addr       (addr),
        .din        (din),
        .ready      (ready),
        .mem_rdata  (mem_rdata),
        .lat_addr   (lat_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .rdata      (dout),
        .busy       (busy),
        .write_mode (write_mode),
        .early_flag (early_ce_flag)
    );

    nvram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (lat_addr),
        .wr_data (mem_wdata),
        .rd_addr (lat_addr),
        .rd_data (mem_rdata)
    );

    // Drive the bus only for an active read with both enables low.
    always_comb begin
        dout_en = ~ce_n & ~oe_n & busy & ~write_mode;
    end
endmodule

// File: rtl/nvram_checker.sv
// Checker: protocol properties of latched_nvram, attached by bind. Keeps its
// own count of precharge clocks to judge each access start.
module nvram_checker #(
    parameter int ADDR_W        = 13,
    parameter int PRECHARGE_CYC = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              ce_n,
    input logic              oe_n,
    input logic              dout_en,
    input logic              busy,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              mem_we,
    input logic              early_ce_flag
);
    localparam int CW = $clog2(PRECHARGE_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(PRECHARGE_CYC);

    logic [CW-1:0] hi_cnt;
    logic          primed;

    // Independent tally of high chip-enable clocks with good supply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            primed <= 1'b0;
        end else begin
            primed <= (hi_cnt == FULL);
            if (!supply_ok || !ce_n) begin
                hi_cnt <= '0;
            end else if (hi_cnt != FULL) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    assert_bus_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n));

    assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_addr));

    assert_precharge_met_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> primed);

    assert_no_write_unpowered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> supply_ok);

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        early_ce_flag |=> early_ce_flag);
endmodule

bind latched_nvram nvram_checker #(
    .ADDR_W        (ADDR_W),
    .PRECHARGE_CYC (PRECHARGE_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .dout_en       (dout_en),
    .busy          (busy),
    .lat_addr      (lat_addr),
    .mem_we        (mem_we),
    .early_ce_flag (early_ce_flag)
);

// File: tb/latched_nvram_test.sv
// Bench: sweeps every address of a small configuration with three write
// styles and two output-enable levels, then probes precharge and supply.
module latched_nvram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int P  = 4;
    localparam int L  = 5;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          early_ce_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    latched_nvram #(
        .ADDR_W(AW), .DATA_W(DW), .PRECHARGE_CYC(P), .ACCESS_LAT(L)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .early_ce_flag(early_ce_flag)
    );

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'(a * 37 + 5);
    endfunction

    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(a * 91) ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_high(input int n);
        ce_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Read access: checks drive enable, hold of old data, then new data.
    task automatic rd(input int a, input logic oe, input logic [DW-1:0] exp);
        hold_high(P);
        addr = AW'(a); we_n = 1'b1; oe_n = oe; ce_n = 1'b0;
        @(negedge clk);
        addr = ~AW'(a);
        check(dout_en == !oe, "R6 dout_en in read", 32'(dout_en), 32'(!oe));
        repeat (L - 1) @(negedge clk);
        check(dout == last_rd, "R5 data held before latency", 32'(dout), 32'(last_rd));
        @(negedge clk);
        check(dout == exp, "R1/R2/R5 read data", 32'(dout), 32'(exp));
        last_rd = exp;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Write ended by write enable rising; address and data disturbed after.
    task automatic wr_we(input int a, input logic [DW-1:0] d);
        hold_high(P);
        addr = AW'(a); we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        addr = ~AW'(a); din = ~d;
        @(negedge clk);
        din = d; we_n = 1'b1;
        @(negedge clk);
        din = ~d;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    // Write ended by chip enable rising, with oe_n low throughout.
    task automatic wr_ce(input int pc, input int a, input logic [DW-1:0] d);
        hold_high(pc);
        addr = AW'(a); we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
        @(negedge clk);
        addr = ~AW'(a);
        check(dout_en == 1'b0, "R6/R7 no drive in write", 32'(dout_en), 32'd0);
        din = d;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        din = ~d; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // Read turned into a write by a late write-enable fall; second pulse ignored.
    task automatic wr_late(input int a, input logic [DW-1:0] d);
        hold_high(P);
        addr = AW'(a); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        addr = ~AW'(a);
        @(negedge clk);
        we_n = 1'b0; din = ~d;
        @(negedge clk);
        din = d; we_n = 1'b1;
        @(negedge clk);
        din = ~d;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check(dout == '0, "R11 dout reset", 32'(dout), 32'd0);
        check(dout_en == 1'b0, "R11 dout_en reset", 32'(dout_en), 32'd0);
        check(early_ce_flag == 1'b0, "R11 flag reset", 32'(early_ce_flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4: write every address via write-enable edge, read back (oe low).
        for (int a = 0; a < N; a++) wr_we(a, pat1(a));
        for (int a = 0; a < N; a++) rd(a, 1'b0, pat1(a));

        // R3 R4 R7: chip-enable-ended writes and late write-enable conversions.
        for (int a = 0; a < N; a++) begin
            if (a % 2 == 0) wr_ce(P, a, pat2(a));
            else            wr_late(a, pat2(a));
        end
        // R5: internal read still happens with oe_n high.
        for (int a = 0; a < N; a++) rd(a, 1'b1, pat2(a));

        // R8: exactly PRECHARGE_CYC high clocks were always accepted.
        check(early_ce_flag == 1'b0, "R8 minimum precharge accepted",
              32'(early_ce_flag), 32'd0);

        // R9: supply low ignores the access and raises no flag.
        supply_ok = 1'b0;
        wr_ce(P + 2, 3, 8'h11);
        check(early_ce_flag == 1'b0, "R9 no flag while supply low",
              32'(early_ce_flag), 32'd0);
        supply_ok = 1'b1;
        // R8 R9 R10: one clock short after supply return is rejected.
        wr_ce(P - 1, 3, 8'h22);
        check(early_ce_flag == 1'b1, "R10 flag on early fall",
              32'(early_ce_flag), 32'd1);
        rd(3, 1'b0, pat2(3));
        check(early_ce_flag == 1'b1, "R10 flag sticky",
              32'(early_ce_flag), 32'd1);

        finished = 1;
        summary();
        $finish;
    end
endmodule